// File: doc/BRIEF.md
# Condition and Flag Unit

This block sits between an instruction decoder and the architectural state of a small processor. It holds the four-bit status register (negative, zero, carry, overflow) and decides, from the instruction's four-bit condition field and the flags held at that moment, whether the current instruction may take effect. When the condition holds, the decoder's requests to redirect the program counter, write the register file or write memory pass through unchanged. When it fails, all three are forced low.

The same execute decision qualifies two separate flag-write requests. One loads the negative and zero pair from the arithmetic unit's result flags. The other loads the carry and overflow pair. Logical operations can therefore set only N and Z, and arithmetic ones can set all four. The condition is always judged on the flags held before the clock edge. A flag-setting instruction therefore decides its own fate on the old flags, and its new flags appear one cycle later.

The unit has no sequencing states. The only storage is the status register, kept as two independently enabled halves. Everything else is combinational from the current inputs and that register.

Top module: `cond_flag_unit`

## Requirements
- R1: While reset is asserted, and directly after it is released, `flags` reads 4'b0000. The bit layout is flags[3]=N, flags[2]=Z, flags[1]=C, flags[0]=V.
- R2: Condition code 4'b1110 always executes: `pc_src`, `reg_write` and `mem_write` equal `pcs_req`, `regw_req` and `memw_req` in the same cycle.
- R3: Code 4'b0000 executes only when Z=1. Code 4'b0001 executes only when Z=0.
- R4: Codes 4'b0010/4'b0011 execute on C=1/C=0. Codes 4'b0100/4'b0101 execute on N=1/N=0. Codes 4'b0110/4'b0111 execute on V=1/V=0.
- R5: Code 4'b1000 executes on C=1 and Z=0. Code 4'b1001 executes on C=0 or Z=1. Code 4'b1010 executes on N==V. Code 4'b1011 executes on N!=V. Code 4'b1100 executes on Z=0 and N==V. Code 4'b1101 executes on Z=1 or N!=V.
- R6: Code 4'b1111 never executes.
- R7: When the condition fails, `pc_src`, `reg_write` and `mem_write` are all 0, whatever the requests.
- R8: When the condition holds and `flagw_req[1]`=1, `flags[3:2]` takes `alu_flags[3:2]` at the rising edge. `flags[1:0]` is untouched unless R9 also applies.
- R9: When the condition holds and `flagw_req[0]`=1, `flags[1:0]` takes `alu_flags[1:0]` at the rising edge. `flags[3:2]` is untouched unless R8 also applies.
- R10: When the condition fails, or `flagw_req` is 2'b00, `flags` keeps its value across the edge.
- R11: The execute decision uses the flags held before the edge. A flag-setting instruction is gated by the old flags, and the new flags appear after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_code | input | 4 | Condition field of the current instruction |
| alu_flags | input | 4 | Result flags from the arithmetic unit, NZCV |
| pcs_req | input | 1 | Decoder request to write the program counter |
| regw_req | input | 1 | Decoder request to write the register file |
| memw_req | input | 1 | Decoder request to write memory |
| flagw_req | input | 2 | Flag-write request: bit 1 for NZ, bit 0 for CV |
| pc_src | output | 1 | Gated program-counter write select |
| reg_write | output | 1 | Gated register-file write enable |
| mem_write | output | 1 | Gated memory write enable |
| flags | output | 4 | Current status register, NZCV |

## Verification
The three gated write outputs are combinational, so they are due in the same cycle as the condition and requests that produce them. The bench drives inputs on the falling edge and samples one time unit later, before any rising edge. A flag update is due one rising edge after the request. The bench therefore loads a flag pattern, crosses exactly one rising edge, and reads `flags` on the following falling edge. For R11, the outputs are read before the edge, judged on the old flags, and the flags are read after it.

// File: rtl/cond_flag_pkg.sv
package cond_flag_pkg;

    localparam int FLAG_W   = 4;
    localparam int FLAG_GRP = 2;
    localparam int GRP_W    = FLAG_W / FLAG_GRP;
    localparam int NUM_REQ  = 3;

    localparam int BIT_N = 3;
    localparam int BIT_Z = 2;
    localparam int BIT_C = 1;
    localparam int BIT_V = 0;

    typedef enum logic [3:0] {
        CC_ZSET   = 4'b0000,
        CC_ZCLR   = 4'b0001,
        CC_CSET   = 4'b0010,
        CC_CCLR   = 4'b0011,
        CC_NSET   = 4'b0100,
        CC_NCLR   = 4'b0101,
        CC_VSET   = 4'b0110,
        CC_VCLR   = 4'b0111,
        CC_UHIGH  = 4'b1000,
        CC_ULOWEQ = 4'b1001,
        CC_SGE    = 4'b1010,
        CC_SLT    = 4'b1011,
        CC_SGT    = 4'b1100,
        CC_SLE    = 4'b1101,
        CC_ALWAYS = 4'b1110,
        CC_NEVER  = 4'b1111
    } cond_e;

endpackage

// File: rtl/cond_check.sv
module cond_check
    import cond_flag_pkg::*;
(
    input  logic [3:0]        cond_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              exec_o
);
    logic n_f, z_f, c_f, v_f;
    cond_e code;

    always_comb begin
        n_f  = flags_i[BIT_N];
        z_f  = flags_i[BIT_Z];
        c_f  = flags_i[BIT_C];
        v_f  = flags_i[BIT_V];
        code = cond_e'(cond_i);
    end

    always_comb begin
        exec_o = 1'b0;
        unique case (code)
            CC_ZSET:   exec_o = z_f;
            CC_ZCLR:   exec_o = ~z_f;
            CC_CSET:   exec_o = c_f;
            CC_CCLR:   exec_o = ~c_f;
            CC_NSET:   exec_o = n_f;
            CC_NCLR:   exec_o = ~n_f;
            CC_VSET:   exec_o = v_f;
            CC_VCLR:   exec_o = ~v_f;
            CC_UHIGH:  exec_o = c_f & ~z_f;
            CC_ULOWEQ: exec_o = ~c_f | z_f;
            CC_SGE:    exec_o = (n_f == v_f);
            CC_SLT:    exec_o = (n_f != v_f);
            CC_SGT:    exec_o = ~z_f & (n_f == v_f);
            CC_SLE:    exec_o = z_f | (n_f != v_f);
            CC_ALWAYS: exec_o = 1'b1;
            CC_NEVER:  exec_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/flag_store.sv
module flag_store
    import cond_flag_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FLAG_GRP-1:0] grp_we_i,
    input  logic [FLAG_W-1:0]   d_i,
    output logic [FLAG_W-1:0]   q_o
);
    for (genvar g = 0; g < FLAG_GRP; g++) begin : g_half
        logic [GRP_W-1:0] half_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                half_q <= '0;
            end else if (grp_we_i[g]) begin
                half_q <= d_i[g*GRP_W +: GRP_W];
            end
        end

        assign q_o[g*GRP_W +: GRP_W] = half_q;
    end
endmodule

// File: rtl/write_gate.sv
module write_gate
    import cond_flag_pkg::*;
(
    input  logic               exec_i,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic [FLAG_GRP-1:0] flagw_i,
    output logic [NUM_REQ-1:0] grant_o,
    output logic [FLAG_GRP-1:0] flag_we_o
);
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
        assign grant_o[i] = req_i[i] & exec_i;
    end

    for (genvar j = 0; j < FLAG_GRP; j++) begin : g_fw
        assign flag_we_o[j] = flagw_i[j] & exec_i;
    end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
    import cond_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] cond_code,
    input  logic [3:0] alu_flags,
    input  logic       pcs_req,
    input  logic       regw_req,
    input  logic       memw_req,
    input  logic [1:0] flagw_req,
    output logic       pc_src,
    output logic       reg_write,
    output logic       mem_write,
    output logic [3:0] flags
);
    logic                exec;
    logic [NUM_REQ-1:0]  req_vec;
    logic [NUM_REQ-1:0]  grant_vec;
    logic [FLAG_GRP-1:0] flag_we;
    logic [FLAG_W-1:0]   flags_q;

    assign req_vec = {pcs_req, regw_req, memw_req};

    cond_check u_check (
        .cond_i  (cond_code),
        .flags_i (flags_q),
        .exec_o  (exec)
    );

    write_gate u_gate (
        .exec_i    (exec),
        .req_i     (req_vec),
        .flagw_i   (flagw_req),
        .grant_o   (grant_vec),
        .flag_we_o (flag_we)
    );

    flag_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .grp_we_i (flag_we),
        .d_i      (alu_flags),
        .q_o      (flags_q)
    );

    assign pc_src    = grant_vec[2];
    assign reg_write = grant_vec[1];
    assign mem_write = grant_vec[0];
    assign flags     = flags_q;
endmodule

// File: rtl/cond_flag_chk.sv
module cond_flag_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cond_code,
    input logic [3:0] alu_flags,
    input logic       pcs_req,
    input logic       regw_req,
    input logic       memw_req,
    input logic [1:0] flagw_req,
    input logic       pc_src,
    input logic       reg_write,
    input logic       mem_write,
    input logic [3:0] flags
);
    p_always_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'b1110) |->
            ({pc_src, reg_write, mem_write} == {pcs_req, regw_req, memw_req}));

    p_zset_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'b0000 && !flags[2]) |->
            !(pc_src || reg_write || mem_write));

    p_never_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'b1111) |-> !(pc_src || reg_write || mem_write));

    p_nz_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'b1110 && flagw_req[1]) |=>
            (flags[3:2] == $past(alu_flags[3:2])));

    p_cv_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'b1110 && flagw_req[0]) |=>
            (flags[1:0] == $past(alu_flags[1:0])));

    p_never_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'b1111) |=> $stable(flags));

    p_nowrite_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flagw_req == 2'b00) |=> $stable(flags));
endmodule

bind cond_flag_unit cond_flag_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cond_code (cond_code),
    .alu_flags (alu_flags),
    .pcs_req   (pcs_req),
    .regw_req  (regw_req),
    .memw_req  (memw_req),
    .flagw_req (flagw_req),
    .pc_src    (pc_src),
    .reg_write (reg_write),
    .mem_write (mem_write),
    .flags     (flags)
);

// File: tb/tb_cond_flag_unit.sv
module tb_cond_flag_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_VEC    = 26;

    // each entry: {flags NZCV, condition code, expected execute}
    localparam logic [8:0] VEC [NUM_VEC] = '{
        9'b0100_0000_1, 9'b0000_0000_0, 9'b0100_0001_0, 9'b0000_0001_1,
        9'b0010_0010_1, 9'b0000_0010_0, 9'b0000_0011_1, 9'b1000_0100_1,
        9'b1000_0101_0, 9'b0001_0110_1, 9'b0001_0111_0, 9'b0010_1000_1,
        9'b0110_1000_0, 9'b0110_1001_1, 9'b0010_1001_0, 9'b1001_1010_1,
        9'b1000_1010_0, 9'b1000_1011_1, 9'b0000_1100_1, 9'b0100_1100_0,
        9'b1000_1100_0, 9'b1000_1101_1, 9'b0000_1101_0, 9'b1111_1110_1,
        9'b0000_1111_0, 9'b1111_1111_0
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cond_code = 4'b1110;
    logic [3:0] alu_flags = 4'b0000;
    logic       pcs_req = 1'b0;
    logic       regw_req = 1'b0;
    logic       memw_req = 1'b0;
    logic [1:0] flagw_req = 2'b00;
    logic       pc_src, reg_write, mem_write;
    logic [3:0] flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    cond_flag_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_code (cond_code),
        .alu_flags (alu_flags),
        .pcs_req   (pcs_req),
        .regw_req  (regw_req),
        .memw_req  (memw_req),
        .flagw_req (flagw_req),
        .pc_src    (pc_src),
        .reg_write (reg_write),
        .mem_write (mem_write),
        .flags     (flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic load_flags(input logic [3:0] f);
        @(negedge clk);
        cond_code = 4'b1110;
        alu_flags = f;
        flagw_req = 2'b11;
        {pcs_req, regw_req, memw_req} = 3'b000;
        @(negedge clk);
        flagw_req = 2'b00;
    endtask

    function automatic string tag_of(input logic [3:0] c);
        if (c <= 4'd1)       return "R3";
        else if (c <= 4'd7)  return "R4";
        else if (c <= 4'd13) return "R5";
        else if (c == 4'd14) return "R2";
        else                 return "R6";
    endfunction

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        #1 check("R1 during reset", flags, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 after release", flags, 4'b0000);

        // table walk: R2-R7 across all condition codes
        for (int i = 0; i < NUM_VEC; i++) begin
            logic [3:0] f, c;
            logic e;
            {f, c, e} = VEC[i];
            load_flags(f);
            check("R1/R8/R9 flag load", flags, f);
            cond_code = c;
            {pcs_req, regw_req, memw_req} = 3'b111;
            #1 check(tag_of(c), {1'b0, pc_src, reg_write, mem_write}, {1'b0, e, e, e});
            if (!e) check("R7 gated", {1'b0, pc_src, reg_write, mem_write}, 4'b0000);
        end

        // R2: mixed requests pass through on always
        @(negedge clk);
        cond_code = 4'b1110;
        flagw_req = 2'b00;
        {pcs_req, regw_req, memw_req} = 3'b101;
        #1 check("R2 mixed", {1'b0, pc_src, reg_write, mem_write}, 4'b0101);

        // R7: failed condition with mixed requests
        cond_code = 4'b1111;
        #1 check("R7 mixed", {1'b0, pc_src, reg_write, mem_write}, 4'b0000);

        // R8: only NZ half loads
        load_flags(4'b0000);
        @(negedge clk);
        cond_code = 4'b1110; alu_flags = 4'b1111; flagw_req = 2'b10;
        @(negedge clk);
        flagw_req = 2'b00;
        check("R8 nz only", flags, 4'b1100);

        // R9: only CV half loads
        @(negedge clk);
        alu_flags = 4'b0011; flagw_req = 2'b01;
        @(negedge clk);
        flagw_req = 2'b00;
        check("R9 cv only", flags, 4'b1111);

        @(negedge clk);
        alu_flags = 4'b0000; flagw_req = 2'b10;
        @(negedge clk);
        flagw_req = 2'b00;
        check("R8 nz clear", flags, 4'b0011);

        // R10: failed condition blocks flag update (Z=0, code 0000)
        @(negedge clk);
        cond_code = 4'b0000; alu_flags = 4'b1100; flagw_req = 2'b11;
        @(negedge clk);
        flagw_req = 2'b00;
        check("R10 failed hold", flags, 4'b0011);

        // R10: no write request keeps flags under always
        @(negedge clk);
        cond_code = 4'b1110; alu_flags = 4'b1100; flagw_req = 2'b00;
        @(negedge clk);
        check("R10 no request", flags, 4'b0011);

        // R11: decision uses old flags (C=1), new flags clear C
        cond_code = 4'b0010; alu_flags = 4'b0000; flagw_req = 2'b11;
        {pcs_req, regw_req, memw_req} = 3'b111;
        #1 check("R11 old flags", {1'b0, pc_src, reg_write, mem_write}, 4'b0111);
        @(negedge clk);
        flagw_req = 2'b00;
        check("R11 new flags", flags, 4'b0000);
        #1 check("R11 now fails", {1'b0, pc_src, reg_write, mem_write}, 4'b0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule